// File: doc/BRIEF.md
# Banked General-Purpose Register File with Privileged Shadow Set

This block holds the integer register state of a 64-bit core: 31 architectural registers and a separate set of 8 shadow registers. When the core runs in its privileged firmware mode, a fixed and non-contiguous group of register numbers is steered to the shadow set. Firmware can then use those registers as scratch space without saving or disturbing the values that ordinary code keeps in them. Outside that mode, every register number selects its architectural register.

The file has two combinational read ports and one write port that updates on the rising clock edge. Each port takes a 5-bit register number. A single mode input decides whether aliasing applies, and it applies to all three ports alike. Register number 31 is the hardwired zero register.

Top module: `gpr_shadow_file`

## Requirements
- R1: With `priv_mode` low, register numbers 0 to 30 read and write architectural registers 0 to 30.
- R2: With `priv_mode` high, register numbers 8 to 14 read and write shadow slots 0 to 6 in that order (number minus 8).
- R3: With `priv_mode` high, register number 25 reads and writes shadow slot 7.
- R4: With `priv_mode` high, every register number other than 8 to 14, 25 and 31 reads and writes its architectural register.
- R5: A write steered to the shadow set leaves the architectural register of the same number unchanged. A write made with `priv_mode` low never changes a shadow slot.
- R6: Register number 31 always reads as zero on both ports, and a write to it changes no register.
- R7: After reset, every architectural register and every shadow slot reads as zero.
- R8: When a read port and the write port select the same physical register in the same cycle, the read returns the value held before the write. The written value appears from the cycle after the clock edge.
- R9: The two read ports are independent. Each returns the register its own number selects, and a read output holds steady while its number and the mode are unchanged and no write occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the write port updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears all registers |
| priv_mode | input | 1 | High while the core is in privileged firmware mode; enables shadow aliasing |
| rd_a_idx | input | 5 | Register number for read port A |
| rd_a_data | output | 64 | Combinational read data for port A |
| rd_b_idx | input | 5 | Register number for read port B |
| rd_b_data | output | 64 | Combinational read data for port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Register number for the write port |
| wr_data | input | 64 | Write data |

## Verification
A read and a write can fall in the same cycle and select the same physical entry. This is where the old-value rule and the aliasing interact. The bench provokes the collision by raising the write to a shadowed number while both read ports name that same number in the same mode. It samples the ports once before the clock edge and expects the old contents, then samples them once after the edge and expects the new value. It also confirms, through a non-privileged read, that the architectural register of that number did not change.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  localparam int unsigned GPR_DATA_W   = 64;
  localparam int unsigned GPR_IDX_W    = 5;
  localparam int unsigned GPR_ARCH_N   = 31;
  localparam int unsigned GPR_SHADOW_N = 8;

  // Register numbers that steer to the shadow set in privileged mode.
  localparam logic [GPR_IDX_W-1:0] RUN_LO    = 5'd8;
  localparam logic [GPR_IDX_W-1:0] RUN_HI    = 5'd14;
  localparam logic [GPR_IDX_W-1:0] LONE_IDX  = 5'd25;
  localparam logic [GPR_IDX_W-1:0] LONE_SLOT = RUN_HI - RUN_LO + 5'd1;
  localparam logic [GPR_IDX_W-1:0] ZERO_IDX  = 5'd31;

  typedef struct packed {
    logic                 to_shadow;
    logic                 is_zero;
    logic [GPR_IDX_W-1:0] slot;
  } gpr_route_t;

  // Map a register number and mode to a physical bank and slot.
  function automatic gpr_route_t route_idx(input logic [GPR_IDX_W-1:0] idx,
                                           input logic priv);
    gpr_route_t r;
    r.is_zero   = (idx == ZERO_IDX);
    r.to_shadow = 1'b0;
    r.slot      = idx;
    if (priv && (idx >= RUN_LO) && (idx <= RUN_HI)) begin
      r.to_shadow = 1'b1;
      r.slot      = idx - RUN_LO;
    end else if (priv && (idx == LONE_IDX)) begin
      r.to_shadow = 1'b1;
      r.slot      = LONE_SLOT;
    end
    return r;
  endfunction

endpackage

// File: rtl/gpr_route.sv
module gpr_route
  import gpr_pkg::*;
(
  input  logic [GPR_IDX_W-1:0] idx,
  input  logic                 priv,
  output gpr_route_t           route
);

  assign route = route_idx(idx, priv);

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] wslot,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SLOT_W-1:0] rslot_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [SLOT_W-1:0] rslot_b,
  output logic [DATA_W-1:0] rdata_b
);

  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem[i] <= '0;
      end else if (we && (wslot == SLOT_W'(i))) begin
        mem[i] <= wdata;
      end
    end
  end

  // Reads come straight from the flops, so a same-cycle write is not seen.
  assign rdata_a = (rslot_a < SLOT_W'(DEPTH)) ? mem[rslot_a[IW-1:0]] : '0;
  assign rdata_b = (rslot_b < SLOT_W'(DEPTH)) ? mem[rslot_b[IW-1:0]] : '0;

endmodule

// File: rtl/gpr_shadow_file.sv
module gpr_shadow_file
  import gpr_pkg::*;
#(
  parameter int unsigned DATA_W   = GPR_DATA_W,
  parameter int unsigned ARCH_N   = GPR_ARCH_N,
  parameter int unsigned SHADOW_N = GPR_SHADOW_N,
  parameter int unsigned IDX_W    = GPR_IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              priv_mode,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data
);

  gpr_route_t route_a, route_b, route_w;

  gpr_route u_route_a (.idx(rd_a_idx), .priv(priv_mode), .route(route_a));
  gpr_route u_route_b (.idx(rd_b_idx), .priv(priv_mode), .route(route_b));
  gpr_route u_route_w (.idx(wr_idx),   .priv(priv_mode), .route(route_w));

  // Named write strobes, one per bank, used by the checker.
  logic arch_we, shadow_we;
  assign arch_we   = wr_en && !route_w.is_zero && !route_w.to_shadow;
  assign shadow_we = wr_en && route_w.to_shadow;

  logic [DATA_W-1:0] arch_a, arch_b, shad_a, shad_b;

  gpr_bank #(.DEPTH(ARCH_N), .DATA_W(DATA_W), .SLOT_W(IDX_W)) u_arch (
    .clk(clk), .rst_n(rst_n),
    .we(arch_we), .wslot(route_w.slot), .wdata(wr_data),
    .rslot_a(route_a.slot), .rdata_a(arch_a),
    .rslot_b(route_b.slot), .rdata_b(arch_b)
  );

  gpr_bank #(.DEPTH(SHADOW_N), .DATA_W(DATA_W), .SLOT_W(IDX_W)) u_shadow (
    .clk(clk), .rst_n(rst_n),
    .we(shadow_we), .wslot(route_w.slot), .wdata(wr_data),
    .rslot_a(route_a.slot), .rdata_a(shad_a),
    .rslot_b(route_b.slot), .rdata_b(shad_b)
  );

  always_comb begin
    if (route_a.is_zero)        rd_a_data = '0;
    else if (route_a.to_shadow) rd_a_data = shad_a;
    else                        rd_a_data = arch_a;
  end

  always_comb begin
    if (route_b.is_zero)        rd_b_data = '0;
    else if (route_b.to_shadow) rd_b_data = shad_b;
    else                        rd_b_data = arch_b;
  end

endmodule

// File: rtl/gpr_file_checks.sv
module gpr_file_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        priv_mode,
  input logic [4:0]  rd_a_idx,
  input logic [63:0] rd_a_data,
  input logic [4:0]  rd_b_idx,
  input logic [63:0] rd_b_data,
  input logic        wr_en,
  input logic [4:0]  wr_idx,
  input logic [63:0] wr_data,
  input logic        arch_we,
  input logic        shadow_we
);

  p_zero_read_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 5'd31) |-> (rd_a_data == 64'd0));

  p_zero_read_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == 5'd31) |-> (rd_b_data == 64'd0));

  p_zero_write_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_idx == 5'd31) |-> (!arch_we && !shadow_we));

  p_one_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arch_we, shadow_we}));

  p_shadow_priv_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_we |-> priv_mode);

  p_arch_spared_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && priv_mode && (((wr_idx >= 5'd8) && (wr_idx <= 5'd14)) || (wr_idx == 5'd25)))
      |-> (shadow_we && !arch_we));

  p_reset_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> ((rd_a_data == 64'd0) && (rd_b_data == 64'd0)));

  p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && ($past(wr_idx) == rd_a_idx) &&
     ($past(priv_mode) == priv_mode) && (rd_a_idx != 5'd31))
      |-> (rd_a_data == $past(wr_data)));

  p_read_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en) && $stable(rd_b_idx) && $stable(priv_mode))
      |-> $stable(rd_b_data));

endmodule

bind gpr_shadow_file gpr_file_checks u_checks (
  .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .arch_we(arch_we), .shadow_we(shadow_we)
);

// File: tb/gpr_shadow_file_bench.sv
module gpr_shadow_file_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        priv_mode = 1'b0;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_a_data, rd_b_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench model of the storage.
  logic [63:0] m_arch [31];
  logic [63:0] m_shad [8];

  always #10 clk = ~clk;  // 50 MHz

  gpr_shadow_file u_gpr_shadow_file (
    .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  function automatic logic [63:0] arch_pat(int i);
    return {32'hA000_0000 | 32'(i), 32'h1234_0000 ^ 32'(i * 7)};
  endfunction

  function automatic logic [63:0] shad_pat(int i);
    return {32'h5E00_0000 | 32'(i), ~32'(i)};
  endfunction

  // Shadow slot for a number in privileged mode, or -1 when none.
  function automatic int shadow_slot(int idx, bit priv);
    if (!priv) return -1;
    case (idx)
      8:  return 0;  9:  return 1;  10: return 2;  11: return 3;
      12: return 4;  13: return 5;  14: return 6;  25: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic logic [63:0] model_read(int idx, bit priv);
    int s;
    s = shadow_slot(idx, priv);
    if (idx == 31) return 64'd0;
    if (s >= 0) return m_shad[s];
    return m_arch[idx];
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(int idx, bit priv, logic [63:0] val);
    int s;
    @(negedge clk);
    priv_mode = priv; wr_en = 1'b1; wr_idx = 5'(idx); wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
    s = shadow_slot(idx, priv);
    if (idx != 31) begin
      if (s >= 0) m_shad[s] = val;
      else        m_arch[idx] = val;
    end
  endtask

  task automatic read_both(int ia, int ib, bit priv, string req);
    @(negedge clk);
    priv_mode = priv; rd_a_idx = 5'(ia); rd_b_idx = 5'(ib);
    #5;
    check({req, " port A"}, rd_a_data, model_read(ia, priv));
    check({req, " port B"}, rd_b_data, model_read(ib, priv));
  endtask

  // R7: everything is zero after reset, in both modes.
  task automatic t_reset_state();
    for (int i = 0; i < 32; i++) read_both(i, 31 - i, 1'b0, "R7 reset arch");
    for (int i = 0; i < 32; i++) read_both(i, 31 - i, 1'b1, "R7 reset priv");
  endtask

  // R1, R9: fill and read the architectural set outside privileged mode.
  task automatic t_arch_fill();
    for (int i = 0; i < 31; i++) do_write(i, 1'b0, arch_pat(i));
    for (int i = 0; i < 31; i++) read_both(i, 30 - i, 1'b0, "R1 R9 arch readback");
  endtask

  // R2, R3, R5: privileged writes land in the shadow set only.
  task automatic t_shadow_fill();
    for (int i = 8; i <= 14; i++) do_write(i, 1'b1, shad_pat(i));
    do_write(25, 1'b1, shad_pat(25));
    for (int i = 8; i <= 14; i++) begin
      read_both(i, 25, 1'b1, "R2 R3 shadow read");
      check("R2 shadow value", rd_a_data, shad_pat(i));
      check("R3 shadow value", rd_b_data, shad_pat(25));
    end
    for (int i = 8; i <= 14; i++) begin
      read_both(i, 25, 1'b0, "R5 arch spared");
      check("R5 arch value", rd_a_data, arch_pat(i));
      check("R5 arch value 25", rd_b_data, arch_pat(25));
    end
  endtask

  // R4: privileged access to other numbers goes to the architectural set.
  task automatic t_priv_passthrough();
    read_both(7, 15, 1'b1, "R4 edge numbers");
    check("R4 number 7", rd_a_data, arch_pat(7));
    check("R4 number 15", rd_b_data, arch_pat(15));
    read_both(24, 26, 1'b1, "R4 around 25");
    check("R4 number 24", rd_a_data, arch_pat(24));
    do_write(20, 1'b1, 64'hC0FF_EE00_0000_0020);
    read_both(20, 0, 1'b0, "R4 priv write arch");
    check("R4 write 20 visible", rd_a_data, 64'hC0FF_EE00_0000_0020);
  endtask

  // R5: a non-privileged write to an aliased number leaves the shadow alone.
  task automatic t_nonpriv_spares_shadow();
    do_write(9, 1'b0, 64'h0BAD_0000_0000_0009);
    read_both(9, 9, 1'b1, "R5 shadow spared");
    check("R5 shadow slot 1", rd_a_data, shad_pat(9));
    read_both(9, 9, 1'b0, "R5 arch written");
    check("R5 arch 9", rd_a_data, 64'h0BAD_0000_0000_0009);
  endtask

  // R6: number 31 reads zero and swallows writes.
  task automatic t_zero_reg();
    do_write(31, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    do_write(31, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    read_both(31, 30, 1'b0, "R6 zero reg");
    check("R6 zero", rd_a_data, 64'd0);
    check("R6 neighbour 30", rd_b_data, arch_pat(30));
    read_both(31, 0, 1'b1, "R6 zero priv");
    check("R6 zero priv", rd_a_data, 64'd0);
  endtask

  // R8: same-cycle read and write of one physical entry.
  task automatic t_read_during_write();
    logic [63:0] oldv, newv;
    oldv = m_shad[4];
    newv = 64'hDEAD_BEEF_0000_0012;
    @(negedge clk);
    priv_mode = 1'b1; rd_a_idx = 5'd12; rd_b_idx = 5'd12;
    wr_en = 1'b1; wr_idx = 5'd12; wr_data = newv;
    #5;
    check("R8 old value port A", rd_a_data, oldv);
    check("R8 old value port B", rd_b_data, oldv);
    @(posedge clk);
    #5;
    check("R8 new value port A", rd_a_data, newv);
    check("R8 new value port B", rd_b_data, newv);
    @(negedge clk);
    wr_en = 1'b0;
    m_shad[4] = newv;
    read_both(12, 12, 1'b0, "R8 R5 arch 12 unchanged");
    check("R5 arch 12", rd_a_data, arch_pat(12));
  endtask

  initial begin
    for (int i = 0; i < 31; i++) m_arch[i] = '0;
    for (int i = 0; i < 8; i++)  m_shad[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_arch_fill();
    t_shadow_fill();
    t_priv_passthrough();
    t_nonpriv_spares_shadow();
    t_zero_reg();
    t_read_during_write();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 to R9 run hung actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule